// File: doc/BRIEF.md
# Per-Lane Register File Cache

This block is a small, hardware-managed cache placed in front of the banked main register file of one SIMT lane. It keeps recently produced destination values for the active warps only. Each active warp slot owns a private group of six 32-bit entries. Every function-unit result is written into the group of its warp unless it comes from a long-latency instruction. An instruction may look up to three source operands in one cycle. A hit returns cached data, and a miss raises a request toward the main register file.

Each warp's group is replaced in FIFO order. When a live value is pushed out, it goes onto the writeback channel. A dead value, flagged as such when it was written, is dropped without a writeback. When the scheduler removes a warp, a flush walks that warp's six entries, oldest first, one per cycle. It writes back every live value and invalidates every entry. Lookups for the warp being flushed are stalled while this happens. All outputs are registered, so results appear one cycle after the inputs are sampled.

Top module: `rfc_lane_cache`

## Requirements
- R1: After reset, no entry is valid, and the outputs `rd_valid`, `rd_stall`, `rd_hit`, `mrf_rd_req`, `wb_valid` and `flush_busy` are all 0.
- R2: A normal (non-long-latency) write to a register not cached for its warp allocates an entry. A later lookup of that warp and register hits and returns the written data.
- R3: Each lookup port is resolved independently, one cycle after `rd_en`. A hit sets its `rd_hit` bit and its 32-bit slice of `rd_data` (port p at bits p*32 upward). A miss sets its `mrf_rd_req` bit, and `mrf_rd_warp`/`mrf_rd_regs` echo the requested warp and registers (port p at bits p*5 upward).
- R4: A write to a register already cached for its warp overwrites that entry in place. It causes no allocation, no eviction and no writeback.
- R5: Replacement is FIFO per warp. Once a warp's six entries are in use, each new register evicts that warp's oldest allocation. Entries of other warps are untouched.
- R6: An evicted entry that was written with `wr_live`=1 appears on `wb_valid`/`wb_warp`/`wb_reg`/`wb_data` in the cycle after the write. An evicted entry written with `wr_live`=0 produces no writeback.
- R7: A write with `wr_longlat`=1 allocates nothing and produces no writeback. It invalidates any cached copy of that register, so a later lookup misses.
- R8: A `flush_req` sampled while idle raises `flush_busy` from the next cycle. The flush then visits the warp's six entries starting at its oldest slot, one per cycle. It writes back each live valid entry in that order and invalidates all of them. With no competing eviction, `flush_busy` lasts exactly six cycles. A `flush_req` sampled while busy is ignored.
- R9: While `flush_busy` is high, a lookup for the warp being flushed returns `rd_stall`=1 with no hit and no request, and a write to that warp is ignored. Lookups and writes for other warps are served normally.
- R10: In a cycle where an eviction writeback occurs, the flush does not advance. Both writebacks are emitted, one after the other, and `flush_busy` lasts one cycle longer.
- R11: A lookup in the same cycle as a normal write to the same warp and register hits and returns the new data. If that same-cycle write is long-latency, the lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Function-unit result write |
| wr_warp | input | 3 | Active warp slot of the result |
| wr_reg | input | 5 | Architectural destination register |
| wr_data | input | 32 | Result value |
| wr_live | input | 1 | 1: value must reach the main file if evicted; 0: dead |
| wr_longlat | input | 1 | Result comes from a long-latency instruction |
| rd_en | input | 1 | Operand lookup request |
| rd_warp | input | 3 | Warp slot of the lookup |
| rd_regs | input | 15 | Three source register numbers, 5 bits each |
| rd_valid | output | 1 | Lookup accepted last cycle |
| rd_stall | output | 1 | Lookup rejected because its warp is flushing |
| rd_hit | output | 3 | Per-port hit |
| rd_data | output | 96 | Per-port data, 32 bits each, 0 on miss |
| mrf_rd_req | output | 3 | Per-port main-file read request (miss) |
| mrf_rd_warp | output | 3 | Warp of the main-file request |
| mrf_rd_regs | output | 15 | Registers of the main-file request |
| wb_valid | output | 1 | Writeback to the main file |
| wb_warp | output | 3 | Writeback warp slot |
| wb_reg | output | 5 | Writeback register |
| wb_data | output | 32 | Writeback value |
| flush_req | input | 1 | Flush a descheduled warp |
| flush_warp | input | 3 | Warp slot to flush |
| flush_busy | output | 1 | Flush in progress |

## Verification
The hardest situation to reach is an eviction of another warp's live entry landing in the middle of a flush walk. In that case the single writeback channel must serve the eviction first and push the remaining flush steps one cycle later. The stimulus fills two warps completely with live values and flushes one of them. Exactly one flush cycle later, it writes a new register to the other, already full warp. The bench then checks the order of the writebacks and the lengthened busy window cycle by cycle. A second flush fills only five entries so that the walk begins at an empty slot. During that walk it injects a stalled lookup, a lookup to another warp, an ignored write and an ignored repeat `flush_req`.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  parameter int unsigned DEF_WARPS  = 8;
  parameter int unsigned DEF_WAYS   = 6;
  parameter int unsigned DEF_REGS   = 32;
  parameter int unsigned DEF_DW     = 32;
  parameter int unsigned DEF_RPORTS = 3;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_WALK = 1'b1
  } fl_state_e;
endpackage

// File: rtl/rfc_way_match.sv
module rfc_way_match #(
  parameter int unsigned WAYS = 6,
  parameter int unsigned RW   = 5,
  parameter int unsigned AW   = 3
) (
  input  logic [WAYS-1:0]    vld_row,
  input  logic [WAYS*RW-1:0] tag_row,
  input  logic [RW-1:0]      key,
  output logic               hit,
  output logic [AW-1:0]      way
);
  // At most one entry per register exists in a warp group.
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (vld_row[i] && (tag_row[i*RW +: RW] == key)) begin
        hit = 1'b1;
        way = AW'(i);
      end
    end
  end
endmodule

// File: rtl/rfc_flush_seq.sv
module rfc_flush_seq
  import rfc_pkg::*;
#(
  parameter int unsigned WAYS = 6,
  parameter int unsigned WW   = 3,
  parameter int unsigned AW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic [WW-1:0] start_warp,
  input  logic          hold,
  input  logic [AW-1:0] head,
  output logic          busy,
  output logic [WW-1:0] warp,
  output logic          step,
  output logic [AW-1:0] way
);
  fl_state_e     st_q;
  logic [AW-1:0] cnt_q;
  logic [AW:0]   sum;

  // Oldest slot first, wrapping around the group.
  always_comb begin
    sum  = {1'b0, head} + {1'b0, cnt_q};
    way  = (sum >= (AW+1)'(WAYS)) ? AW'(sum - (AW+1)'(WAYS)) : AW'(sum);
    busy = (st_q == FL_WALK);
    step = busy && !hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FL_IDLE;
      cnt_q <= '0;
      warp  <= '0;
    end else begin
      case (st_q)
        FL_IDLE: if (start_req) begin
          st_q  <= FL_WALK;
          warp  <= start_warp;
          cnt_q <= '0;
        end
        FL_WALK: if (step) begin
          if (cnt_q == AW'(WAYS-1)) st_q <= FL_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= FL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfc_lane_cache.sv
module rfc_lane_cache
  import rfc_pkg::*;
#(
  parameter int unsigned WARPS  = DEF_WARPS,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned REGS   = DEF_REGS,
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned RPORTS = DEF_RPORTS,
  localparam int unsigned WW  = $clog2(WARPS),
  localparam int unsigned AW  = $clog2(WAYS),
  localparam int unsigned RW  = $clog2(REGS),
  localparam int unsigned ENT = WARPS * WAYS,
  localparam int unsigned EW  = $clog2(ENT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [WW-1:0]        wr_warp,
  input  logic [RW-1:0]        wr_reg,
  input  logic [DW-1:0]        wr_data,
  input  logic                 wr_live,
  input  logic                 wr_longlat,
  input  logic                 rd_en,
  input  logic [WW-1:0]        rd_warp,
  input  logic [RPORTS*RW-1:0] rd_regs,
  output logic                 rd_valid,
  output logic                 rd_stall,
  output logic [RPORTS-1:0]    rd_hit,
  output logic [RPORTS*DW-1:0] rd_data,
  output logic [RPORTS-1:0]    mrf_rd_req,
  output logic [WW-1:0]        mrf_rd_warp,
  output logic [RPORTS*RW-1:0] mrf_rd_regs,
  output logic                 wb_valid,
  output logic [WW-1:0]        wb_warp,
  output logic [RW-1:0]        wb_reg,
  output logic [DW-1:0]        wb_data,
  input  logic                 flush_req,
  input  logic [WW-1:0]        flush_warp,
  output logic                 flush_busy
);
  logic [ENT-1:0] vld_q, live_q;
  logic [RW-1:0]  tag_q  [ENT];
  logic [DW-1:0]  data_q [ENT];
  logic [AW-1:0]  fptr_q [WARPS];

  function automatic logic [EW-1:0] ent_idx(input logic [WW-1:0] w, input logic [AW-1:0] a);
    return EW'(int'(w) * int'(WAYS) + int'(a));
  endfunction

  // ---------------- flush sequencer ----------------
  logic          fl_busy, fl_step, ev_fire, fl_wb_c;
  logic [WW-1:0] fl_warp;
  logic [AW-1:0] fl_way;
  logic [EW-1:0] fl_ent;

  rfc_flush_seq #(.WAYS(WAYS), .WW(WW), .AW(AW)) i_flush (
    .clk(clk), .rst(rst), .start_req(flush_req), .start_warp(flush_warp),
    .hold(ev_fire), .head(fptr_q[fl_warp]), .busy(fl_busy), .warp(fl_warp),
    .step(fl_step), .way(fl_way)
  );

  assign fl_ent     = ent_idx(fl_warp, fl_way);
  assign fl_wb_c    = fl_step && vld_q[fl_ent] && live_q[fl_ent];
  assign flush_busy = fl_busy;

  // ---------------- write path ----------------
  logic [WAYS-1:0]    wr_vrow, rd_vrow;
  logic [WAYS*RW-1:0] wr_trow, rd_trow;
  logic               wr_ok, wr_hit, alloc;
  logic [AW-1:0]      wr_way;
  logic [EW-1:0]      vict, wr_tgt;

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      wr_vrow[i]           = vld_q[ent_idx(wr_warp, AW'(i))];
      wr_trow[i*RW +: RW]  = tag_q[ent_idx(wr_warp, AW'(i))];
      rd_vrow[i]           = vld_q[ent_idx(rd_warp, AW'(i))];
      rd_trow[i*RW +: RW]  = tag_q[ent_idx(rd_warp, AW'(i))];
    end
  end

  rfc_way_match #(.WAYS(WAYS), .RW(RW), .AW(AW)) i_wr_match (
    .vld_row(wr_vrow), .tag_row(wr_trow), .key(wr_reg), .hit(wr_hit), .way(wr_way)
  );

  assign wr_ok   = wr_en && !(fl_busy && (wr_warp == fl_warp));
  assign alloc   = wr_ok && !wr_longlat && !wr_hit;
  assign vict    = ent_idx(wr_warp, fptr_q[wr_warp]);
  assign ev_fire = alloc && vld_q[vict] && live_q[vict];
  assign wr_tgt  = wr_hit ? ent_idx(wr_warp, wr_way) : vict;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      live_q <= '0;
      for (int w = 0; w < WARPS; w++) fptr_q[w] <= '0;
    end else begin
      if (fl_step) vld_q[fl_ent] <= 1'b0;
      if (wr_ok && wr_longlat && wr_hit) begin
        vld_q[wr_tgt] <= 1'b0;
      end else if (wr_ok && !wr_longlat) begin
        vld_q[wr_tgt]  <= 1'b1;
        live_q[wr_tgt] <= wr_live;
        if (!wr_hit)
          fptr_q[wr_warp] <= (fptr_q[wr_warp] == AW'(WAYS-1)) ? '0 : fptr_q[wr_warp] + 1'b1;
      end
    end
  end

  // Storage without reset, single write port.
  always_ff @(posedge clk) begin
    if (wr_ok && !wr_longlat) begin
      data_q[wr_tgt] <= wr_data;
      tag_q[wr_tgt]  <= wr_reg;
    end
  end

  // Single writeback channel: eviction first, flush otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_warp  <= '0;
      wb_reg   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= ev_fire || fl_wb_c;
      if (ev_fire) begin
        wb_warp <= wr_warp;
        wb_reg  <= tag_q[vict];
        wb_data <= data_q[vict];
      end else if (fl_wb_c) begin
        wb_warp <= fl_warp;
        wb_reg  <= tag_q[fl_ent];
        wb_data <= data_q[fl_ent];
      end
    end
  end

  // ---------------- lookup ports ----------------
  logic [RPORTS-1:0] hit_c;
  logic [DW-1:0]     dat_c [RPORTS];
  logic              rd_stall_c, rd_go;

  for (genvar p = 0; p < RPORTS; p++) begin : g_port
    logic          m_hit, byp;
    logic [AW-1:0] m_way;
    logic [RW-1:0] key;
    assign key = rd_regs[p*RW +: RW];
    rfc_way_match #(.WAYS(WAYS), .RW(RW), .AW(AW)) i_match (
      .vld_row(rd_vrow), .tag_row(rd_trow), .key(key), .hit(m_hit), .way(m_way)
    );
    assign byp      = wr_ok && (wr_warp == rd_warp) && (wr_reg == key);
    assign hit_c[p] = byp ? !wr_longlat : m_hit;
    assign dat_c[p] = byp ? wr_data : data_q[ent_idx(rd_warp, m_way)];
  end

  assign rd_stall_c = rd_en && fl_busy && (rd_warp == fl_warp);
  assign rd_go      = rd_en && !rd_stall_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_stall    <= 1'b0;
      rd_hit      <= '0;
      rd_data     <= '0;
      mrf_rd_req  <= '0;
      mrf_rd_warp <= '0;
      mrf_rd_regs <= '0;
    end else begin
      rd_valid    <= rd_go;
      rd_stall    <= rd_stall_c;
      rd_hit      <= rd_go ? hit_c : '0;
      mrf_rd_req  <= rd_go ? ~hit_c : '0;
      mrf_rd_warp <= rd_warp;
      mrf_rd_regs <= rd_regs;
      for (int p = 0; p < RPORTS; p++)
        rd_data[p*DW +: DW] <= (rd_go && hit_c[p]) ? dat_c[p] : '0;
    end
  end
endmodule

// File: rtl/rfc_lane_cache_chk.sv
module rfc_lane_cache_chk #(
  parameter int unsigned RPORTS = 3,
  parameter int unsigned WW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [WW-1:0]     rd_warp,
  input logic              rd_valid,
  input logic              rd_stall,
  input logic [RPORTS-1:0] rd_hit,
  input logic [RPORTS-1:0] mrf_rd_req,
  input logic              wb_valid,
  input logic              wr_en,
  input logic              wr_longlat,
  input logic              flush_req,
  input logic              flush_busy,
  input logic [WW-1:0]     fl_warp,
  input logic              fl_step,
  input logic              fl_wb_c,
  input logic              ev_fire
);
  // R10: eviction and flush step never share the writeback channel
  a_r10_one_wb_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_fire, fl_step}));

  // R9: lookup of the flushing warp is stalled
  a_r9_stall_flushing: assert property (@(posedge clk) disable iff (rst)
    rd_en && flush_busy && (rd_warp == fl_warp) |=> rd_stall && !rd_valid);

  // R9: a stalled lookup neither hits nor requests
  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    rd_stall |-> (rd_hit == '0) && (mrf_rd_req == '0));

  // R8: accepted flush request raises busy next cycle
  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    flush_req && !flush_busy |=> flush_busy);

  // R8: a flush step over a dead or empty entry emits nothing
  a_r8_flush_dead_silent: assert property (@(posedge clk) disable iff (rst)
    fl_step && !fl_wb_c |=> !wb_valid);

  // R7: a long-latency write never evicts
  a_r7_longlat_no_wb: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_longlat && !fl_step |=> !wb_valid);
endmodule

bind rfc_lane_cache rfc_lane_cache_chk #(.RPORTS(RPORTS), .WW(WW)) i_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_warp(rd_warp), .rd_valid(rd_valid),
  .rd_stall(rd_stall), .rd_hit(rd_hit), .mrf_rd_req(mrf_rd_req), .wb_valid(wb_valid),
  .wr_en(wr_en), .wr_longlat(wr_longlat), .flush_req(flush_req), .flush_busy(flush_busy),
  .fl_warp(fl_warp), .fl_step(fl_step), .fl_wb_c(fl_wb_c), .ev_fire(ev_fire)
);

// File: tb/test_rfc_lane_cache.sv
module test_rfc_lane_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, wr_live = 0, wr_longlat = 0, rd_en = 0, flush_req = 0;
  logic [2:0]  wr_warp = 0, rd_warp = 0, flush_warp = 0;
  logic [4:0]  wr_reg = 0;
  logic [31:0] wr_data = 0;
  logic [14:0] rd_regs = 0;
  logic        rd_valid, rd_stall, wb_valid, flush_busy;
  logic [2:0]  rd_hit, mrf_rd_req, mrf_rd_warp, wb_warp;
  logic [95:0] rd_data;
  logic [14:0] mrf_rd_regs;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rfc_lane_cache i_rfc_lane_cache (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    wr_en = 0; wr_live = 0; wr_longlat = 0; rd_en = 0; flush_req = 0;
  endtask

  task automatic set_wr(input int w, input int r, input logic [31:0] d, input logic lv, input logic ll);
    wr_en = 1; wr_warp = 3'(w); wr_reg = 5'(r); wr_data = d; wr_live = lv; wr_longlat = ll;
  endtask

  task automatic set_rd(input int w, input int r0, input int r1, input int r2);
    rd_en = 1; rd_warp = 3'(w); rd_regs = {5'(r2), 5'(r1), 5'(r0)};
  endtask

  task automatic wr(input int w, input int r, input logic [31:0] d, input logic lv, input logic ll);
    set_wr(w, r, d, lv, ll); tick(); clr();
  endtask

  task automatic rd(input int w, input int r0, input int r1, input int r2);
    set_rd(w, r0, r1, r2); tick(); clr();
  endtask

  task automatic t_reset();
    check("R1 rd_valid", rd_valid, 0);
    check("R1 wb_valid", wb_valid, 0);
    check("R1 flush_busy", flush_busy, 0);
    rd(0, 1, 2, 3);
    check("R1 all miss after reset", rd_hit, 3'b000);
    check("R3 miss requests", mrf_rd_req, 3'b111);
    check("R3 request regs", mrf_rd_regs, {5'd3, 5'd2, 5'd1});
  endtask

  task automatic t_fill_hit();
    wr(0, 5, 32'hA5A5_0005, 1, 0);
    check("R2 no wb on first fill", wb_valid, 0);
    rd(0, 5, 6, 5);
    check("R3 hit pattern", rd_hit, 3'b101);
    check("R3 request pattern", mrf_rd_req, 3'b010);
    check("R2 port0 data", rd_data[31:0], 32'hA5A5_0005);
    check("R3 port1 zero", rd_data[63:32], 0);
    check("R3 port2 data", rd_data[95:64], 32'hA5A5_0005);
    check("R3 request warp", mrf_rd_warp, 0);
  endtask

  task automatic t_fifo();
    for (int r = 1; r <= 6; r++) wr(1, r, 32'(100 + r), (r != 2), 0);
    wr(1, 7, 32'd107, 1, 0);
    check("R6 live eviction wb", wb_valid, 1);
    check("R5 evicts oldest reg", wb_reg, 1);
    check("R6 wb warp", wb_warp, 1);
    check("R6 wb data", wb_data, 101);
    wr(1, 8, 32'd108, 1, 0);
    check("R6 dead eviction silent", wb_valid, 0);
    rd(1, 1, 3, 2);
    check("R5 hit after eviction", rd_hit, 3'b010);
    check("R5 surviving data", rd_data[63:32], 103);
    wr(1, 3, 32'h333, 1, 0);
    check("R4 update no wb", wb_valid, 0);
    rd(1, 3, 4, 7);
    check("R4 all still cached", rd_hit, 3'b111);
    check("R4 updated data", rd_data[31:0], 32'h333);
    rd(0, 5, 5, 5);
    check("R5 other warp untouched", rd_hit, 3'b111);
  endtask

  task automatic t_longlat();
    wr(0, 5, 32'hDEAD, 1, 1);
    check("R7 no wb", wb_valid, 0);
    rd(0, 5, 0, 0);
    check("R7 dropped copy misses", rd_hit[0], 0);
    check("R7 request for dropped", mrf_rd_req[0], 1);
  endtask

  task automatic t_bypass();
    set_wr(2, 9, 32'hBEEF_0009, 1, 0);
    set_rd(2, 9, 10, 9);
    tick(); clr();
    check("R11 bypass hit", rd_hit, 3'b101);
    check("R11 bypass data", rd_data[95:64], 32'hBEEF_0009);
    set_wr(2, 9, 32'h1, 1, 1);
    set_rd(2, 9, 9, 9);
    tick(); clr();
    check("R11 long-latency bypass misses", rd_hit, 3'b000);
  endtask

  task automatic t_flush();
    for (int r = 10; r <= 14; r++) wr(3, r, 32'h3000_0000 + 32'(r), (r != 14), 0);
    flush_req = 1; flush_warp = 3; tick(); clr();
    check("R8 busy rises", flush_busy, 1);
    for (int i = 1; i <= 6; i++) begin
      if (i == 1) set_rd(3, 10, 11, 12);
      if (i == 2) set_rd(1, 3, 4, 7);
      if (i == 3) set_wr(3, 20, 32'h20, 1, 0);
      if (i == 4) begin flush_req = 1; flush_warp = 3; end
      tick(); clr();
      if (i == 1) begin
        check("R9 stall flushing warp", rd_stall, 1);
        check("R9 stalled no request", mrf_rd_req, 0);
      end
      if (i == 2) check("R9 other warp served", rd_hit, 3'b111);
      if (i >= 2 && i <= 5) begin
        check("R8 flush wb order", {wb_valid, wb_warp, wb_reg}, {1'b1, 3'd3, 5'(8 + i)});
        check("R8 flush wb data", wb_data, 32'h3000_0000 + 32'(8 + i));
      end else begin
        check("R8 no wb empty or dead", wb_valid, 0);
      end
      check("R8 busy window", flush_busy, (i < 6));
    end
    tick();
    check("R8 repeat request ignored", flush_busy, 0);
    rd(3, 10, 20, 11);
    check("R8 R9 flushed warp misses", rd_hit, 3'b000);
  endtask

  task automatic t_conflict();
    for (int r = 1; r <= 6; r++) wr(4, r, 32'h4000_0000 + 32'(r), 1, 0);
    for (int r = 1; r <= 6; r++) wr(5, r, 32'h5000_0000 + 32'(r), 1, 0);
    flush_req = 1; flush_warp = 4; tick(); clr();
    for (int i = 1; i <= 7; i++) begin
      if (i == 2) set_wr(5, 7, 32'h5000_0007, 1, 0);
      tick(); clr();
      if (i == 2) begin
        check("R10 eviction first", {wb_valid, wb_warp, wb_reg}, {1'b1, 3'd5, 5'd1});
        check("R10 eviction data", wb_data, 32'h5000_0001);
      end else begin
        check("R10 flush resumes", {wb_valid, wb_warp, wb_reg},
              {1'b1, 3'd4, 5'((i == 1) ? 1 : i - 1)});
      end
      check("R10 stretched busy", flush_busy, (i < 7));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_fill_hit();
    t_fifo();
    t_longlat();
    t_bypass();
    t_flush();
    t_conflict();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule